// File: doc/BRIEF.md
# Stipple and Blit Drawing Engine

This block is a small framebuffer drawing accelerator that sits behind a 32-bit write port. Every drawing operation takes two writes. The first write, with address bit 2 clear, parks a colour word in a holding register. The second write, with address bit 2 set, names the destination pixel through its address bits and starts the work. Starting an operation does not change the holding register. A mode input picks how the command word is read. In stipple mode the word is a 32-pixel mask. In blit mode the word packs a source pixel address and a run length, and the run is either filled with the held colour or copied from the source.

While it works, the engine drives a synchronous pixel memory with 8-bit pixels and raises `busy`. A second memory port, which shares the pixel address, holds one 32-bit control word per pixel. That port is written only when both the raw-mode input and the deep-colour input are high at the moment a command is accepted. Bus decoding and display scan-out belong to the neighbouring blocks.

Top module: `stipblit_engine`

## Requirements
- R1: A write with `wr_addr[2]` = 0 only loads `wr_data` into the holding register. It starts no memory access and does not raise `busy`.
- R2: A write with `wr_addr[2]` = 1 and `busy` low starts an operation. The destination pixel address is `wr_addr` shifted right by 3, so bits 1:0 have no effect.
- R3: In stipple mode (`wr_blit` = 0) the engine steps through 32 positions, one per cycle. Mask bit 31 maps to destination+0 and bit 0 maps to destination+31. A set bit writes held bits 7:0 to that pixel. A clear bit leaves the pixel untouched.
- R4: In blit mode (`wr_blit` = 1), command bits 28:24 hold the run length minus one, so a run covers 1 to 32 pixels. Bits 23:0 hold the source address.
- R5: When the 24-bit source field is 0xFFFFFF, the run is filled with held bits 7:0, one pixel per cycle.
- R6: Any other source value copies the run in ascending order. Each pixel takes two cycles, a read of source+i followed by a write of destination+i. Overlapping runs therefore behave as a forward copy.
- R7: `rd_data` is always zero.
- R8: When `raw_mode` and `deep_mode` are both high at command acceptance, every pixel write also writes the control plane at the same address. Stipple and fill write {8'h00, held bits 23:0}. A copy writes the word read from the source. Otherwise `cp_en` stays low for the whole operation.
- R9: A command write that arrives while `busy` is high is dropped. `err` pulses high for one cycle, in the cycle after that write.
- R10: `done` is high for exactly one cycle, in the cycle after the last pixel cycle. `busy` falls in that same cycle. `busy` lasts 32 cycles for a stipple, L cycles for a fill and 2L cycles for a copy, where L is the run length.
- R11: After reset, `busy`, `done`, `err`, `pm_en` and `cp_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | PIX_AW+3 | Byte address of the write within the engine window |
| wr_data | input | 32 | Write data |
| wr_blit | input | 1 | Command mode: 1 selects blit, 0 selects stipple |
| raw_mode | input | 1 | Enables control-plane updates |
| deep_mode | input | 1 | 24-bit colour configuration; needed for control-plane updates |
| rd_data | output | 32 | Read data, always zero |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| err | output | 1 | One-cycle pulse for a dropped command |
| pm_en | output | 1 | Pixel memory access enable |
| pm_we | output | 1 | Pixel memory write enable |
| pm_addr | output | PIX_AW | Pixel address, shared by both memory ports |
| pm_wdata | output | 8 | Pixel write data |
| pm_rdata | input | 8 | Pixel read data, one cycle after a read |
| cp_en | output | 1 | Control-plane access enable |
| cp_we | output | 1 | Control-plane write enable |
| cp_wdata | output | 32 | Control-plane write data |
| cp_rdata | input | 32 | Control-plane read data, one cycle after a read |

## Verification
`busy` rises on the first clock edge after a command write. It then stays high for 32, L or 2L cycles, and `done` is due in the cycle where `busy` falls. The bench drives every input on the falling edge and counts, at each later falling edge, the cycles in which `busy` is high. It compares that count with the value its own model expects, then checks `done` in the exit cycle and again one cycle later. `err` is due one cycle after a rejected write, and the bench samples it at exactly that falling edge. Memory contents are checked only after `done`, by comparing the whole bench memory with a reference model that applied the operation in ascending pixel order.

// File: rtl/stb_pkg.sv
package stb_pkg;

    typedef enum logic [1:0] {
        OP_STIP = 2'd0,
        OP_FILL = 2'd1,
        OP_COPY = 2'd2
    } stb_op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_STIP = 3'd1,
        ST_FILL = 3'd2,
        ST_CRD  = 3'd3,
        ST_CWR  = 3'd4
    } stb_state_e;

    typedef struct packed {
        logic [31:0] held;
        logic        err;
    } stb_front_t;

endpackage

// File: rtl/stb_cmd_decode.sv
module stb_cmd_decode
    import stb_pkg::*;
#(
    parameter int PIX_AW = 20,
    parameter int SRC_W  = 24,
    parameter int LEN_W  = 5
) (
    input  logic                    wr_blit,
    input  logic [PIX_AW+2:0]       wr_addr,
    input  logic [31:0]             wr_data,
    output stb_op_e                 op,
    output logic [PIX_AW-1:0]       dst,
    output logic [PIX_AW-1:0]       src,
    output logic [LEN_W-1:0]        last,
    output logic [(1<<LEN_W)-1:0]   mask
);
    localparam int MASK_W = 1 << LEN_W;

    logic [SRC_W-1:0] src_field;
    logic             fill_code;
    logic             unused_bits;

    always_comb begin
        src_field = wr_data[SRC_W-1:0];
        fill_code = &src_field;
        dst       = wr_addr[PIX_AW+2:3];
        src       = src_field[PIX_AW-1:0];
        mask      = wr_data[MASK_W-1:0];
        if (!wr_blit) begin
            op   = OP_STIP;
            last = '1;
        end else begin
            op   = fill_code ? OP_FILL : OP_COPY;
            last = wr_data[SRC_W +: LEN_W];
        end
    end

    assign unused_bits = ^{wr_addr[2:0], wr_data[31:SRC_W+LEN_W], src_field[SRC_W-1:PIX_AW]};

endmodule

// File: rtl/stb_seq.sv
module stb_seq
    import stb_pkg::*;
#(
    parameter int PIX_AW = 20,
    parameter int LEN_W  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  stb_op_e                op,
    input  logic [PIX_AW-1:0]      dst,
    input  logic [PIX_AW-1:0]      src,
    input  logic [LEN_W-1:0]       last,
    input  logic [(1<<LEN_W)-1:0]  mask,
    input  logic [23:0]            colour,
    input  logic                   plane,
    input  logic [7:0]             pm_rdata,
    input  logic [31:0]            cp_rdata,
    output logic                   busy,
    output logic                   done,
    output logic                   pm_en,
    output logic                   pm_we,
    output logic [PIX_AW-1:0]      pm_addr,
    output logic [7:0]             pm_wdata,
    output logic                   cp_en,
    output logic                   cp_we,
    output logic [31:0]            cp_wdata
);
    localparam int MASK_W = 1 << LEN_W;

    typedef struct packed {
        stb_state_e         st;
        logic [PIX_AW-1:0]  dst;
        logic [PIX_AW-1:0]  src;
        logic [LEN_W-1:0]   idx;
        logic [LEN_W-1:0]   last;
        logic [MASK_W-1:0]  mask;
        logic [23:0]        col;
        logic               plane;
        logic               done;
    } seq_t;

    seq_t q, d;
    logic at_last;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        at_last  = (q.idx == q.last);
        pm_en    = 1'b0;
        pm_we    = 1'b0;
        pm_addr  = q.dst + PIX_AW'(q.idx);
        pm_wdata = q.col[7:0];
        cp_en    = 1'b0;
        cp_we    = 1'b0;
        cp_wdata = {8'h00, q.col};
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.dst   = dst;
                    d.src   = src;
                    d.idx   = '0;
                    d.last  = last;
                    d.mask  = mask;
                    d.col   = colour;
                    d.plane = plane;
                    case (op)
                        OP_STIP: d.st = ST_STIP;
                        OP_FILL: d.st = ST_FILL;
                        default: d.st = ST_CRD;
                    endcase
                end
            end
            ST_STIP: begin
                pm_en  = q.mask[MASK_W-1];
                pm_we  = pm_en;
                cp_en  = pm_en & q.plane;
                cp_we  = cp_en;
                d.mask = q.mask << 1;
                if (at_last) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_FILL: begin
                pm_en = 1'b1;
                pm_we = 1'b1;
                cp_en = q.plane;
                cp_we = q.plane;
                if (at_last) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_CRD: begin
                pm_en   = 1'b1;
                pm_addr = q.src + PIX_AW'(q.idx);
                cp_en   = q.plane;
                d.st    = ST_CWR;
            end
            ST_CWR: begin
                pm_en    = 1'b1;
                pm_we    = 1'b1;
                pm_wdata = pm_rdata;
                cp_en    = q.plane;
                cp_we    = q.plane;
                cp_wdata = cp_rdata;
                if (at_last) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                    d.st  = ST_CRD;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != ST_IDLE);
    assign done = q.done;

    // R6: every copy read is followed directly by the matching write
    a_r6_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_en && !pm_we) |=> (pm_en && pm_we));

    // R8: the control plane only moves together with the pixel memory
    a_r8_plane_with_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        cp_en |-> (pm_en && (cp_we == pm_we)));

    // R10: done is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done appears as busy falls
    a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

endmodule

// File: rtl/stipblit_engine.sv
module stipblit_engine
    import stb_pkg::*;
#(
    parameter int PIX_AW = 20,
    parameter int SRC_W  = 24,
    parameter int LEN_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PIX_AW+2:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               wr_blit,
    input  logic               raw_mode,
    input  logic               deep_mode,
    output logic [31:0]        rd_data,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               pm_en,
    output logic               pm_we,
    output logic [PIX_AW-1:0]  pm_addr,
    output logic [7:0]         pm_wdata,
    input  logic [7:0]         pm_rdata,
    output logic               cp_en,
    output logic               cp_we,
    output logic [31:0]        cp_wdata,
    input  logic [31:0]        cp_rdata
);
    localparam int MASK_W = 1 << LEN_W;

    stb_front_t fq, fd;
    logic       cmd_wr;
    logic       start;
    logic       unused_held;

    stb_op_e              dec_op;
    logic [PIX_AW-1:0]    dec_dst;
    logic [PIX_AW-1:0]    dec_src;
    logic [LEN_W-1:0]     dec_last;
    logic [MASK_W-1:0]    dec_mask;

    always_comb begin
        fd     = fq;
        cmd_wr = wr_en & wr_addr[2];
        start  = cmd_wr & ~busy;
        fd.err = cmd_wr & busy;
        if (wr_en && !wr_addr[2]) begin
            fd.held = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fq <= '0;
        end else begin
            fq <= fd;
        end
    end

    stb_cmd_decode #(
        .PIX_AW (PIX_AW),
        .SRC_W  (SRC_W),
        .LEN_W  (LEN_W)
    ) u_dec (
        .wr_blit (wr_blit),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .op      (dec_op),
        .dst     (dec_dst),
        .src     (dec_src),
        .last    (dec_last),
        .mask    (dec_mask)
    );

    stb_seq #(
        .PIX_AW (PIX_AW),
        .LEN_W  (LEN_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (dec_op),
        .dst      (dec_dst),
        .src      (dec_src),
        .last     (dec_last),
        .mask     (dec_mask),
        .colour   (fq.held[23:0]),
        .plane    (raw_mode & deep_mode),
        .pm_rdata (pm_rdata),
        .cp_rdata (cp_rdata),
        .busy     (busy),
        .done     (done),
        .pm_en    (pm_en),
        .pm_we    (pm_we),
        .pm_addr  (pm_addr),
        .pm_wdata (pm_wdata),
        .cp_en    (cp_en),
        .cp_we    (cp_we),
        .cp_wdata (cp_wdata)
    );

    assign err         = fq.err;
    assign rd_data     = '0;
    assign unused_held = ^fq.held[31:24];

    // R9: a rejected command can only follow a busy cycle
    a_r9_err_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(busy));

    // R1: no memory traffic while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!pm_en && !cp_en));

endmodule

// File: tb/stipblit_engine_tb.sv
module stipblit_engine_tb;
    localparam int PIX_AW = 20;
    localparam int MW     = 4096;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [PIX_AW+2:0]  wr_addr = '0;
    logic [31:0]        wr_data = '0;
    logic               wr_blit = 1'b0;
    logic               raw_mode = 1'b0;
    logic               deep_mode = 1'b0;
    logic [31:0]        rd_data;
    logic               busy, done, err;
    logic               pm_en, pm_we, cp_en, cp_we;
    logic [PIX_AW-1:0]  pm_addr;
    logic [7:0]         pm_wdata;
    logic [7:0]         pm_rdata = '0;
    logic [31:0]        cp_wdata;
    logic [31:0]        cp_rdata = '0;

    logic [7:0]  mem [MW];
    logic [31:0] cpm [MW];
    logic [7:0]  rmem [MW];
    logic [31:0] rcpm [MW];
    logic [31:0] held = '0;
    int          n_chk = 0;
    int          n_err = 0;
    int          pm_cnt = 0;
    int          cp_cnt = 0;

    always #5 clk = ~clk;

    stipblit_engine #(.PIX_AW(PIX_AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_blit(wr_blit), .raw_mode(raw_mode),
        .deep_mode(deep_mode), .rd_data(rd_data), .busy(busy), .done(done),
        .err(err), .pm_en(pm_en), .pm_we(pm_we), .pm_addr(pm_addr),
        .pm_wdata(pm_wdata), .pm_rdata(pm_rdata), .cp_en(cp_en), .cp_we(cp_we),
        .cp_wdata(cp_wdata), .cp_rdata(cp_rdata)
    );

    always @(posedge clk) begin
        if (pm_en) begin
            pm_cnt = pm_cnt + 1;
            if (pm_we) mem[pm_addr[11:0]] <= pm_wdata;
            else       pm_rdata <= mem[pm_addr[11:0]];
        end
        if (cp_en) begin
            cp_cnt = cp_cnt + 1;
            if (cp_we) cpm[pm_addr[11:0]] <= cp_wdata;
            else       cp_rdata <= cpm[pm_addr[11:0]];
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_cycles(input bit blit, input logic [31:0] data);
        int len;
        len = int'(data[28:24]) + 1;
        if (!blit) return 32;
        if (data[23:0] == 24'hFFFFFF) return len;
        return 2 * len;
    endfunction

    task automatic ref_apply(input bit blit, input int dst, input logic [31:0] data, input bit pl);
        int len;
        len = int'(data[28:24]) + 1;
        if (!blit) begin
            for (int i = 0; i < 32; i++) begin
                if (data[31-i]) begin
                    rmem[(dst+i)%MW] = held[7:0];
                    if (pl) rcpm[(dst+i)%MW] = {8'h00, held[23:0]};
                end
            end
        end else if (data[23:0] == 24'hFFFFFF) begin
            for (int i = 0; i < len; i++) begin
                rmem[(dst+i)%MW] = held[7:0];
                if (pl) rcpm[(dst+i)%MW] = {8'h00, held[23:0]};
            end
        end else begin
            for (int i = 0; i < len; i++) begin
                rmem[(dst+i)%MW] = rmem[(int'(data[23:0])+i)%MW];
                if (pl) rcpm[(dst+i)%MW] = rcpm[(int'(data[23:0])+i)%MW];
            end
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad, first;
        bad = 0;
        first = -1;
        for (int i = 0; i < MW; i++) begin
            if (mem[i] !== rmem[i] || cpm[i] !== rcpm[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) first = 0;
        check(bad == 0, {req, " memory"}, {24'h0, mem[first], cpm[first]},
              {24'h0, rmem[first], rcpm[first]});
    endtask

    task automatic put_colour(input logic [31:0] c, input int dst_bits);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = {PIX_AW'(dst_bits), 3'b011};
        wr_data = c;
        @(negedge clk);
        wr_en = 1'b0;
        held  = c;
    endtask

    task automatic run_op(input bit blit, input int dst, input logic [31:0] data,
                          input bit intrude, input string req);
        int cycles, exp;
        bit pl;
        pl  = raw_mode & deep_mode;
        exp = exp_cycles(blit, data);
        ref_apply(blit, dst, data, pl);
        cp_cnt = 0;
        @(negedge clk);
        wr_en   = 1'b1;
        wr_blit = blit;
        wr_addr = {PIX_AW'(dst), 3'b111};
        wr_data = data;
        @(negedge clk);
        wr_en  = 1'b0;
        cycles = 0;
        while (busy && cycles < 300) begin
            cycles++;
            if (intrude && cycles == 2) begin
                wr_en   = 1'b1;
                wr_blit = 1'b1;
                wr_addr = {PIX_AW'(40), 3'b100};
                wr_data = 32'h1FFF_FFFF;
            end
            if (intrude && cycles == 3) begin
                wr_en = 1'b0;
                check(err == 1'b1, "R9 err pulse", err, 1);
            end
            check(rd_data == 32'h0, "R7 read zero", rd_data, 0);
            @(negedge clk);
        end
        check(cycles == exp, {req, " R10 busy length"}, cycles, exp);
        check(done == 1'b1, "R10 done at end", done, 1);
        if (intrude) check(err == 1'b0, "R9 err single", err, 0);
        if (!pl) check(cp_cnt == 0, "R8 plane idle", cp_cnt, 0);
        @(negedge clk);
        check(done == 1'b0, "R10 done one cycle", done, 0);
        cmp_mem(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int dst, src, len;
        logic [31:0] d;
        bit b;
        void'($urandom(32'd20240611));
        for (int i = 0; i < MW; i++) begin
            mem[i]  = 8'(i * 7 + 3);
            rmem[i] = 8'(i * 7 + 3);
            cpm[i]  = 32'(i) * 32'h0001_0103;
            rcpm[i] = 32'(i) * 32'h0001_0103;
        end
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!busy && !done && !err && !pm_en && !cp_en, "R11 reset outputs",
              {busy, done, err, pm_en, cp_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data == 32'h0, "R7 read zero idle", rd_data, 0);

        // R1 data write touches nothing
        pm_cnt = 0;
        put_colour(32'h00A1_B2C3, 500);
        repeat (3) @(negedge clk);
        check(pm_cnt == 0 && !busy && !done, "R1 data write quiet", pm_cnt, 0);

        // R3 and R2: stipple with end bits, low address bits ignored
        run_op(1'b0, 100, 32'h8000_0001, 1'b0, "R3 R2 stipple ends");
        run_op(1'b0, 300, 32'h0000_0000, 1'b0, "R3 stipple empty");
        put_colour(32'h0011_2233, 7);
        run_op(1'b0, 400, 32'hF0F0_5AA5, 1'b0, "R3 stipple pattern");

        // R5 and R4: fill of length 1 and 32
        run_op(1'b1, 600, 32'h00FF_FFFF, 1'b0, "R5 R4 fill len 1");
        run_op(1'b1, 700, 32'h1FFF_FFFF, 1'b0, "R5 R4 fill len 32");

        // R6: plain copy and overlapping forward copy
        run_op(1'b1, 900, 32'h0700_0100, 1'b0, "R6 copy len 8");
        run_op(1'b1, 201, 32'h0700_00C8, 1'b0, "R6 overlap forward");

        // R8 plane updates only with both modes set
        raw_mode = 1'b1;
        deep_mode = 1'b0;
        run_op(1'b1, 1000, 32'h03FF_FFFF, 1'b0, "R8 raw only");
        deep_mode = 1'b1;
        put_colour(32'h5566_7788, 9);
        run_op(1'b0, 1100, 32'hC003_0081, 1'b0, "R8 plane stipple");
        run_op(1'b1, 1200, 32'h1F00_1100, 1'b0, "R8 plane copy");
        run_op(1'b1, 1300, 32'h04FF_FFFF, 1'b0, "R8 plane fill");

        // R9 command while busy dropped
        run_op(1'b0, 1400, 32'hFFFF_0000, 1'b1, "R9 dropped command");

        // random mix
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            raw_mode  = 1'($urandom % 2);
            deep_mode = 1'($urandom % 2);
            if ($urandom % 4 == 0) put_colour($urandom, int'($urandom % 4000));
            b   = 1'($urandom % 2);
            dst = 64 + int'($urandom % 2900);
            src = 64 + int'($urandom % 2900);
            len = int'($urandom % 32);
            if (!b) d = $urandom;
            else if ($urandom % 3 == 0) d = {3'b000, 5'(len), 24'hFFFFFF};
            else d = {3'b000, 5'(len), 24'(src)};
            run_op(b, dst, d, 1'b0, b ? "R4 R5 R6 random blit" : "R3 random stipple");
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule